// File: doc/BRIEF.md
# Factorial Compute Register Unit

This block is a small compute engine behind a 32-bit register port. Software writes an operand into the value register. The unit then forms the factorial of that operand over several clock cycles, doing one multiply per cycle. While it works, a busy flag shows in the status register. When it finishes, the result replaces the operand in the same value register.

A writable enable bit in the status register decides whether the unit raises a one-cycle completion cause pulse. The port also carries a constant identification word and a scratch register. The scratch register keeps the bitwise complement of whatever is written to it, so a driver can confirm that the port is alive.

Only full 32-bit accesses are accepted. An access of any other size leaves the state untouched, and a read of that size returns all ones. Reads are combinational in the cycle of the request. Writes take effect at the next rising clock edge.

Top module: `fact_compute_unit`

## Requirements
- R1: A 4-byte read of byte offset 0x00 returns the constant 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise complement of the written data. A read of 0x04 returns the stored word.
- R3: A 4-byte write to offset 0x08 while busy is clear loads the operand and sets status bit 0 (busy) from the next cycle. A write to 0x08 while busy is set is dropped. Until completion, reads of 0x08 return the loaded operand.
- R4: The result is N·(N−1)·…·1 with each product truncated to 32 bits. Operands 0 and 1 both give 1.
- R5: Busy clears exactly max(N,1) clock edges after the edge that loaded operand N. From that cycle on, offset 0x08 reads the result.
- R6: Status bit 7 is read/write. If bit 7 is set at the completion edge, irq_o is high for exactly the one cycle in which busy first reads 0. Otherwise irq_o stays low.
- R7: Writes to status bit 0 and to status bits other than bit 7 have no effect. Those other bits read 0.
- R8: When size_i is not 4, writes change nothing and reads return 0xFFFFFFFF.
- R9: The mapped offsets are 0x00, 0x04, 0x08 and status at 0x20. Reads of any other offset return 0xFFFFFFFF, and writes to any other offset change nothing.
- R10: After reset, 0x04, 0x08 and the status register all read 0, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| size_i | input | 4 | Access size in bytes; only 4 is accepted |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | One-cycle completion cause pulse |

## Verification
The factorial path is tried with several kinds of operand, and each kind exposes a different class of fault.
- Operands 0 and 1 separate a correct one-cycle completion from an off-by-one in the termination test.
- Operands 2, 5 and 12 fit in 32 bits, so they check the product chain and the exact busy length.
- Operands 13 and 20 overflow, so they show whether the truncation wraps correctly.
- Operand 34 contains 2^32 as a factor, so its wrapped result must be exactly zero.

Each run is repeated with the enable bit set and cleared, and with the enable changed while the unit is busy. This shows that the pulse uses the value of the bit at completion. Extra writes to 0x08 during a run check that busy drops them.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int unsigned OFF_ID    = 'h00;
  localparam int unsigned OFF_LIVE  = 'h04;
  localparam int unsigned OFF_VAL   = 'h08;
  localparam int unsigned OFF_STAT  = 'h20;
  localparam int unsigned ACC_BYTES = 4;

  typedef enum logic [2:0] {
    SEL_ID,
    SEL_LIVE,
    SEL_VAL,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/fact_regif.sv
module fact_regif
  import fact_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output reg_sel_e          sel_o,
  output logic              size_ok_o,
  output logic              wr_o
);
  assign size_ok_o = (size_i == SIZE_W'(ACC_BYTES));
  assign wr_o      = req_i & we_i & size_ok_o;

  always_comb begin
    if      (addr_i == ADDR_W'(OFF_ID))   sel_o = SEL_ID;
    else if (addr_i == ADDR_W'(OFF_LIVE)) sel_o = SEL_LIVE;
    else if (addr_i == ADDR_W'(OFF_VAL))  sel_o = SEL_VAL;
    else if (addr_i == ADDR_W'(OFF_STAT)) sel_o = SEL_STAT;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  logic              busy_q;
  logic [DATA_W-1:0] acc_q, cnt_q;

  // last step once the down-counter has reached 1 (or started at 0)
  assign done_o   = busy_q && (cnt_q <= DATA_W'(1));
  assign busy_o   = busy_q;
  assign result_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      acc_q  <= DATA_W'(1);
      cnt_q  <= operand_i;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
      end else begin
        acc_q <= DATA_W'(acc_q * cnt_q);
        cnt_q <= cnt_q - DATA_W'(1);
      end
    end
  end

  a_r3_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r5_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o && !start_i) |=> busy_q);
  a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o && !start_i) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));
  a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/fact_compute_unit.sv
module fact_compute_unit
  import fact_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SIZE_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h010000ED,
  parameter int unsigned BUSY_BIT = 0,
  parameter int unsigned IEN_BIT  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              size_ok, wr;
  logic              eng_busy, eng_done, start;
  logic [DATA_W-1:0] eng_result;
  logic [DATA_W-1:0] live_q, val_q, stat_word;
  logic              ien_q, irq_q;

  fact_regif #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_regif (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .size_i   (size_i),
    .sel_o    (sel),
    .size_ok_o(size_ok),
    .wr_o     (wr)
  );

  // operand writes are dropped while a run is in flight
  assign start = wr && (sel == SEL_VAL) && !eng_busy;

  fact_engine #(.DATA_W(DATA_W)) i_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .operand_i(wdata_i),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .result_o (eng_result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      val_q  <= '0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= eng_done & ien_q;
      if (wr && sel == SEL_LIVE) live_q <= ~wdata_i;
      if (wr && sel == SEL_STAT) ien_q <= wdata_i[IEN_BIT];
      if (eng_done)   val_q <= eng_result;
      else if (start) val_q <= wdata_i;
    end
  end

  always_comb begin
    stat_word           = '0;
    stat_word[BUSY_BIT] = eng_busy;
    stat_word[IEN_BIT]  = ien_q;
  end

  always_comb begin
    rdata_o = '1;
    if (size_ok) begin
      unique case (sel)
        SEL_ID:   rdata_o = DATA_W'(ID_VALUE);
        SEL_LIVE: rdata_o = live_q;
        SEL_VAL:  rdata_o = val_q;
        SEL_STAT: rdata_o = stat_word;
        default:  rdata_o = '1;
      endcase
    end
  end

  assign irq_o = irq_q;

  a_r2_live_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_LIVE) |=> (live_q == ~$past(wdata_i)));
  a_r3_busy_drops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_VAL && eng_busy && !eng_done) |=> (val_q == $past(val_q)));
  a_r5_result_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> (val_q == $past(eng_result)));
  a_r6_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(eng_done) && $past(ien_q)));
  a_r8_bad_size_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i != SIZE_W'(ACC_BYTES)) |-> (rdata_o == '1));
endmodule

// File: tb/test_fact_compute_unit.sv
`timescale 1ns/1ps
module test_fact_compute_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  size = 4'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R10";

  // behavioural reference state
  logic [31:0] m_live, m_val;
  bit          m_busy, m_ien, m_irq;
  int          m_rem;
  logic [31:0] m_op;

  always #2 clk = ~clk;

  fact_compute_unit i_fact_compute_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] fact_ref(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (int k = 2; k <= int'(n); k++) r = r * 32'(k);
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [3:0] s);
    if (s != 4'd4) return 32'hFFFF_FFFF;
    case (a)
      8'h00: return 32'h010000ED;
      8'h04: return m_live;
      8'h08: return m_val;
      8'h20: return {24'h0, m_ien, 6'h0, m_busy};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = '0; m_val = '0; m_busy = 0; m_ien = 0; m_irq = 0; m_rem = 0; m_op = '0;
    end else begin
      bit ok, finishing;
      ok = req && we && size == 4'd4;
      finishing = m_busy && m_rem == 1;
      m_irq = finishing && m_ien;
      if (ok && addr == 8'h04) m_live = ~wdata;
      if (ok && addr == 8'h20) m_ien = wdata[7];
      if (finishing) begin
        m_busy = 0;
        m_val = fact_ref(m_op);
      end else if (m_busy) begin
        m_rem--;
      end else if (ok && addr == 8'h08) begin
        m_busy = 1;
        m_op = wdata;
        m_val = wdata;
        m_rem = (wdata <= 32'd1) ? 1 : int'(wdata);
      end
    end
  end

  task automatic check_now();
    logic [31:0] er;
    vectors++;
    if (req && !we) begin
      er = exp_read(addr, size);
      if (rdata !== er) begin
        fails++;
        $display("FAIL %s rdata addr=%02h size=%0d actual=%08h expected=%08h",
                 cur_req, addr, size, rdata, er);
      end
    end
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", cur_req, irq, m_irq);
    end
  endtask

  task automatic cyc(input bit r, input bit w, input logic [7:0] a,
                     input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; size = s;
    #1 check_now();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'd4);
    cyc(1, 1, a, d, s);
  endtask
  task automatic rd(input logic [7:0] a, input logic [3:0] s = 4'd4);
    cyc(1, 0, a, '0, s);
  endtask
  task automatic idle();
    cyc(0, 0, '0, '0, 4'd4);
  endtask

  // R3 R4 R5 R6: one factorial run
  task automatic run_fact(input logic [31:0] n, input bit ien, input bit flip_ien);
    cur_req = "R6"; wr(8'h20, ien ? 32'h80 : 32'h0);
    cur_req = "R3"; wr(8'h08, n);
    rd(8'h08);
    rd(8'h20);
    if (n >= 4) begin
      wr(8'h08, 32'd7);
      rd(8'h08);
    end
    if (flip_ien) begin
      cur_req = "R6"; wr(8'h20, ien ? 32'h0 : 32'h80);
    end
    cur_req = "R5";
    while (m_busy) rd(8'h20);
    rd(8'h20);
    cur_req = "R4"; rd(8'h08);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R10";
    rd(8'h04); rd(8'h08); rd(8'h20); idle();
    cur_req = "R1";  rd(8'h00);
    cur_req = "R2";
    wr(8'h04, 32'h12345678); rd(8'h04);
    wr(8'h04, 32'h0); rd(8'h04);
    cur_req = "R8";
    wr(8'h04, 32'hA5A5A5A5, 4'd2); rd(8'h04);
    rd(8'h04, 4'd8); rd(8'h00, 4'd1);
    wr(8'h08, 32'd5, 4'd8); rd(8'h20); rd(8'h08);
    wr(8'h20, 32'h80, 4'd1); rd(8'h20);
    cur_req = "R9";
    rd(8'h10); rd(8'h05); rd(8'h80); rd(8'hFC); rd(8'h24);
    wr(8'h10, 32'h0); wr(8'h0C, 32'd3); wr(8'h09, 32'd3);
    rd(8'h04); rd(8'h08); rd(8'h20);
    cur_req = "R7";
    wr(8'h20, 32'h1); rd(8'h20); rd(8'h08);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20);
    wr(8'h20, 32'h7F); rd(8'h20);
    run_fact(32'd0, 1, 0);
    run_fact(32'd1, 0, 0);
    run_fact(32'd2, 1, 0);
    run_fact(32'd5, 0, 0);
    run_fact(32'd12, 1, 0);
    run_fact(32'd13, 1, 1);
    run_fact(32'd20, 0, 1);
    run_fact(32'd34, 1, 0);
    run_fact(32'd3, 1, 0);
    cur_req = "R6";
    repeat (3) idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule